// File: doc/BRIEF.md
# Receiver DC Offset Calibration Sequencer

This block steps a receiver through its start-up work each time the three-bit mode field is set to the receive code. It first waits a fixed bias-settling interval. It may then run a filter-tune phase, which is completed by a handshake from the tuner. Next it runs a DC offset calibration, either full length or short precharge, or it skips calibration altogether. At the end it enables the receive path by itself.

The full calibration length comes from a three-bit time select: a base count shifted left by the select value. The precharge routine has its own fixed length. While either calibration runs, the LNA and LO buffer stay off unless their force-on bits are set. In normal receive the LO buffer is on, and the LNA follows the gain enable. A disable input holds the offset corrector at zero and makes every calibration request void. If the mode field leaves the receive code, the sequence aborts at once. All outputs are registered.

Top module: `rx_dcoc_seq`

## Requirements
- R1: After a synchronous reset, every output is low.
- R2: A move from idle to mode 3'b111 starts a hold-off of HOLD_CYC cycles (390 with default parameters). During the hold-off every enable and `rx_ready` are low. Any other mode code leaves the sequencer idle.
- R3: `offset_zero` follows `cal_off` one cycle later. When `cal_off` is high at the moment calibration would begin, no `cal_en` cycle occurs and receive mode follows directly.
- R4: If `tune_req` is high in the cycle receive mode is entered, `tune_en` is high from the end of the hold-off until `tune_done` is seen. Calibration, or receive, starts in the next cycle.
- R5: A full calibration, where `cal_off`, `cal_skip` and `prech_only` are all low, holds `cal_en` and `bb_clk_en` high for CAL_BASE << `cal_time` cycles (16 << sel by default). `cal_time` is sampled when calibration starts.
- R6: With `prech_only` high and `cal_skip` low, `cal_en` is high for PRE_CYC cycles (8 by default) in place of the full length.
- R7: With `cal_skip` high, no calibration runs, whatever `prech_only` is. Receive mode follows the hold-off, or the tune.
- R8: While `cal_en` is high, `lna_en` equals `lna_force` and `lo_en` equals `lo_force`.
- R9: In receive mode `rx_ready` and `lo_en` are high, `lna_en` equals `lna_gain`, and `cal_en`, `bb_clk_en` and `tune_en` are low.
- R10: A mode other than 3'b111 in any state drops every enable and `rx_ready` on the next cycle. A later re-entry restarts the full hold-off.

Every phase lasts exactly its cycle count, and the next phase starts on the following cycle with no gap. The outputs change one clock edge after the cycle in which a decision is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operating mode; 3'b111 is receive |
| tune_req | input | 1 | Request a filter tune on receive entry |
| cal_off | input | 1 | Disable calibration; hold corrector at zero |
| cal_skip | input | 1 | Skip calibration |
| prech_only | input | 1 | Use the short precharge routine |
| cal_time | input | 3 | Full calibration length select |
| lna_gain | input | 1 | LNA enable in normal receive |
| lna_force | input | 1 | LNA on during calibration |
| lo_force | input | 1 | LO buffer on during calibration |
| tune_done | input | 1 | Filter tune finished |
| tune_en | output | 1 | Filter tune running |
| cal_en | output | 1 | Offset calibration running |
| bb_clk_en | output | 1 | Baseband calibration clock enable |
| lna_en | output | 1 | LNA enable |
| lo_en | output | 1 | LO buffer enable |
| offset_zero | output | 1 | Hold offset corrector at its zero value |
| rx_ready | output | 1 | Normal receive reached |

## Verification
Two events can land in the same cycle. One is the end of one timed phase and the start of the next. The other is the handover from the tune handshake to calibration. Both are provoked by running the chain straight through: hold-off, then tune, then calibration, then receive. The bench counts the cycles of each output pattern, so a single lost or doubled cycle at a boundary shows up as a wrong count. An abort is also placed in the middle of a long calibration, and the select is changed while calibration is running. These show whether a mode change, or a late select change, in the same cycle as a timer step is judged correctly.

// File: rtl/rx_dcoc_pkg.sv
package rx_dcoc_pkg;
  localparam logic [2:0] MODE_RX = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_TUNE  = 3'd2,
    ST_CAL   = 3'd3,
    ST_PRECH = 3'd4,
    ST_RX    = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic tune_en;
    logic cal_en;
    logic bb_clk_en;
    logic lna_en;
    logic lo_en;
    logic rx_ready;
  } seq_out_t;
endpackage

// File: rtl/dcoc_timer.sv
module dcoc_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  // A phase loaded with N lasts N cycles: N in its first cycle, 1 in its last.
  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dcoc_len_sel.sv
module dcoc_len_sel
  import rx_dcoc_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int HOLD_CYC = 390,
  parameter int CAL_BASE = 16,
  parameter int PRE_CYC  = 8
) (
  input  seq_state_t       next_st,
  input  logic [2:0]       cal_time,
  output logic [CNT_W-1:0] load_val
);
  localparam int N_SEL = 8;

  logic [CNT_W-1:0] cal_len [N_SEL];

  // Lengths of the eight full calibrations, one per select value.
  for (genvar g = 0; g < N_SEL; g++) begin : g_len
    assign cal_len[g] = CNT_W'(CAL_BASE << g);
  end

  always_comb begin
    unique case (next_st)
      ST_HOLD:  load_val = CNT_W'(HOLD_CYC);
      ST_CAL:   load_val = cal_len[cal_time];
      ST_PRECH: load_val = CNT_W'(PRE_CYC);
      default:  load_val = '0;
    endcase
  end
endmodule

// File: rtl/dcoc_seq_ctrl.sv
module dcoc_seq_ctrl
  import rx_dcoc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       tune_req,
  input  logic       cal_off,
  input  logic       cal_skip,
  input  logic       prech_only,
  input  logic       tune_done,
  input  logic       expire,
  output seq_state_t state_q,
  output seq_state_t state_d,
  output logic       load
);
  logic       tune_pend_q;
  seq_state_t cal_next;

  // Step that follows the hold-off (and the tune, if one was asked for).
  always_comb begin
    if (cal_off || cal_skip) cal_next = ST_RX;
    else if (prech_only)     cal_next = ST_PRECH;
    else                     cal_next = ST_CAL;
  end

  always_comb begin
    state_d = state_q;
    if (mode != MODE_RX) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_HOLD;
        ST_HOLD:  if (expire) state_d = tune_pend_q ? ST_TUNE : cal_next;
        ST_TUNE:  if (tune_done) state_d = cal_next;
        ST_CAL,
        ST_PRECH: if (expire) state_d = ST_RX;
        ST_RX:    state_d = ST_RX;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  assign load = (state_d != state_q) &&
                (state_d == ST_HOLD || state_d == ST_CAL || state_d == ST_PRECH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      tune_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && state_d == ST_HOLD) tune_pend_q <= tune_req;
      else if (state_d == ST_IDLE)                  tune_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_dcoc_seq.sv
module rx_dcoc_seq
  import rx_dcoc_pkg::*;
#(
  parameter int REF_CLK_KHZ = 26000,
  parameter int HOLDOFF_NS  = 15000,
  parameter int CAL_BASE    = 16,
  parameter int PRE_CYC     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       tune_req,
  input  logic       cal_off,
  input  logic       cal_skip,
  input  logic       prech_only,
  input  logic [2:0] cal_time,
  input  logic       lna_gain,
  input  logic       lna_force,
  input  logic       lo_force,
  input  logic       tune_done,
  output logic       tune_en,
  output logic       cal_en,
  output logic       bb_clk_en,
  output logic       lna_en,
  output logic       lo_en,
  output logic       offset_zero,
  output logic       rx_ready
);
  localparam int HOLD_CYC = (REF_CLK_KHZ / 1000) * HOLDOFF_NS / 1000;
  localparam int CAL_MAX  = CAL_BASE << 7;
  localparam int MAX_A    = (HOLD_CYC > CAL_MAX) ? HOLD_CYC : CAL_MAX;
  localparam int MAX_LEN  = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  seq_state_t       state_q, state_d;
  logic             load, expire;
  logic [CNT_W-1:0] load_val;
  seq_out_t         out_d, out_q;
  logic             zero_q;

  dcoc_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .tune_req  (tune_req),
    .cal_off   (cal_off),
    .cal_skip  (cal_skip),
    .prech_only(prech_only),
    .tune_done (tune_done),
    .expire    (expire),
    .state_q   (state_q),
    .state_d   (state_d),
    .load      (load)
  );

  dcoc_len_sel #(
    .CNT_W   (CNT_W),
    .HOLD_CYC(HOLD_CYC),
    .CAL_BASE(CAL_BASE),
    .PRE_CYC (PRE_CYC)
  ) u_len (
    .next_st (state_d),
    .cal_time(cal_time),
    .load_val(load_val)
  );

  dcoc_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val(load_val),
    .expire  (expire)
  );

  // Output pattern for the state being entered; registered so it lines up with state_q.
  always_comb begin
    out_d = '0;
    unique case (state_d)
      ST_TUNE: begin
        out_d.tune_en   = 1'b1;
        out_d.bb_clk_en = 1'b1;
      end
      ST_CAL, ST_PRECH: begin
        out_d.cal_en    = 1'b1;
        out_d.bb_clk_en = 1'b1;
        out_d.lna_en    = lna_force;
        out_d.lo_en     = lo_force;
      end
      ST_RX: begin
        out_d.rx_ready = 1'b1;
        out_d.lo_en    = 1'b1;
        out_d.lna_en   = lna_gain;
      end
      default: out_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      zero_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      zero_q <= cal_off;
    end
  end

  assign tune_en     = out_q.tune_en;
  assign cal_en      = out_q.cal_en;
  assign bb_clk_en   = out_q.bb_clk_en;
  assign lna_en      = out_q.lna_en;
  assign lo_en       = out_q.lo_en;
  assign rx_ready    = out_q.rx_ready;
  assign offset_zero = zero_q;
endmodule

// File: rtl/rx_dcoc_seq_chk.sv
module rx_dcoc_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode,
  input logic       tune_req,
  input logic       cal_off,
  input logic       cal_skip,
  input logic       prech_only,
  input logic [2:0] cal_time,
  input logic       lna_gain,
  input logic       lna_force,
  input logic       lo_force,
  input logic       tune_done,
  input logic       tune_en,
  input logic       cal_en,
  input logic       bb_clk_en,
  input logic       lna_en,
  input logic       lo_en,
  input logic       offset_zero,
  input logic       rx_ready
);
  assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'b111) |=> !(tune_en || cal_en || bb_clk_en || lna_en || lo_en || rx_ready));

  assert_no_cal_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_en) |-> !$past(cal_off));

  assert_zero_follow_R3: assert property (@(posedge clk) disable iff (rst)
    offset_zero == $past(cal_off));

  assert_cal_clock_R5: assert property (@(posedge clk) disable iff (rst)
    cal_en |-> bb_clk_en);

  assert_force_R8: assert property (@(posedge clk) disable iff (rst)
    cal_en |-> (lna_en == $past(lna_force)) && (lo_en == $past(lo_force)));

  assert_rx_path_R9: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> lo_en && !cal_en && !bb_clk_en && (lna_en == $past(lna_gain)));

  assert_one_phase_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tune_en, cal_en, rx_ready}));
endmodule

bind rx_dcoc_seq rx_dcoc_seq_chk u_chk (.*);

// File: tb/tb_rx_dcoc_seq.sv
module tb_rx_dcoc_seq;
  localparam int HOLD = 390;
  localparam int BASE = 16;
  localparam int PRE  = 8;
  localparam int TL   = 4;
  localparam int NV   = 9;
  // {cal_off, skip, prech, tune, tsel[2:0], gain, lna_force, lo_force}
  localparam logic [9:0] VEC [NV] = '{
    10'b0000_000_1_0_0,
    10'b0000_111_0_1_0,
    10'b0001_011_1_0_1,
    10'b0010_000_1_1_1,
    10'b0100_000_1_0_0,
    10'b1001_000_0_0_0,
    10'b0011_101_0_1_0,
    10'b0110_000_1_0_0,
    10'b1010_000_1_1_1
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] mode = 3'b000, cal_time = 3'd0;
  logic tune_req = 0, cal_off = 0, cal_skip = 0, prech_only = 0;
  logic lna_gain = 0, lna_force = 0, lo_force = 0, tune_done = 0;
  logic tune_en, cal_en, bb_clk_en, lna_en, lo_en, offset_zero, rx_ready;
  int errors = 0, checks = 0, tcnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rx_dcoc_seq dut (.*);

  // Filter-tune model: reports done on the TL-th cycle it sees tune_en.
  always @(negedge clk) begin
    if (!tune_en) begin
      tcnt <= 0; tune_done <= 1'b0;
    end else begin
      tcnt <= tcnt + 1; tune_done <= (tcnt + 1 == TL);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [9:0] c);
    {cal_off, cal_skip, prech_only, tune_req, cal_time, lna_gain, lna_force, lo_force} = c;
  endtask

  // Enter receive at a falling edge, then count the samples of each phase.
  task automatic run_seq(output int nh, output int nt, output int nc,
                         output int nbad, output bit rx);
    nh = 0; nt = 0; nc = 0; nbad = 0; rx = 0;
    mode = 3'b111;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (rx_ready) begin rx = 1; break; end
      if (tune_en) nt++;
      else if (cal_en) begin
        nc++;
        if (lna_en != lna_force || lo_en != lo_force || !bb_clk_en) nbad++;
      end else if (nt == 0 && nc == 0) nh++;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int nh, nt, nc, nbad, ec;
    bit rx;
    logic [9:0] c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk({tune_en, cal_en, bb_clk_en, lna_en, lo_en, offset_zero, rx_ready} == 7'd0,
        "R1 reset outputs", {tune_en, cal_en, bb_clk_en, lna_en, lo_en, offset_zero, rx_ready}, 0);

    for (int v = 0; v < NV; v++) begin
      c = VEC[v];
      @(negedge clk);
      apply(c);
      run_seq(nh, nt, nc, nbad, rx);
      ec = (c[9] || c[8]) ? 0 : (c[7] ? PRE : (BASE << c[5:3]));
      chk(nh == HOLD, "R2 hold-off length", nh, HOLD);
      chk(nt == (c[6] ? TL : 0), "R4 tune phase", nt, c[6] ? TL : 0);
      chk(nc == ec, "R5/R6/R7/R3 cal length", nc, ec);
      chk(nbad == 0, "R8 force bits during cal", nbad, 0);
      chk(rx && lo_en && !cal_en && !bb_clk_en && lna_en == lna_gain,
          "R9 receive outputs", {rx, lo_en, cal_en, bb_clk_en, lna_en}, {1'b1, 1'b1, 1'b0, 1'b0, lna_gain});
      chk(offset_zero == cal_off, "R3 offset_zero", offset_zero, cal_off);
      mode = 3'b000;
      @(negedge clk);
      chk({tune_en, cal_en, bb_clk_en, lna_en, lo_en, rx_ready} == 6'd0, "R10 abort from receive",
          {tune_en, cal_en, bb_clk_en, lna_en, lo_en, rx_ready}, 0);
    end

    // R2: a non-receive code keeps the sequencer idle
    apply(10'b0000_000_1_1_1);
    mode = 3'b011;
    ec = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (tune_en || cal_en || bb_clk_en || lna_en || lo_en || rx_ready) ec++;
    end
    chk(ec == 0, "R2 other mode stays idle", ec, 0);

    // R10: abort mid-calibration, then re-entry restarts the hold-off
    apply(10'b0000_111_0_1_1);
    mode = 3'b111;
    repeat (HOLD + 100) @(negedge clk);
    chk(cal_en == 1'b1, "R5 calibrating before abort", cal_en, 1);
    mode = 3'b000;
    @(negedge clk);
    chk({cal_en, bb_clk_en, lna_en, lo_en} == 4'd0, "R10 abort mid-cal",
        {cal_en, bb_clk_en, lna_en, lo_en}, 0);
    @(negedge clk);
    apply(10'b0000_001_0_0_0);
    run_seq(nh, nt, nc, nbad, rx);
    chk(nh == HOLD, "R10 re-entry hold-off restarts", nh, HOLD);
    chk(nc == BASE * 2, "R5 length after re-entry", nc, BASE * 2);
    mode = 3'b000;
    @(negedge clk);

    // R5: select changed during calibration has no effect on its length
    @(negedge clk);
    apply(10'b0000_010_0_0_0);
    mode = 3'b111;
    nc = 0;
    for (int i = 0; i < HOLD + 300; i++) begin
      @(negedge clk);
      if (cal_en) begin
        nc++;
        if (nc == 10) cal_time = 3'd7;
      end
    end
    chk(nc == BASE * 4, "R5 select sampled at start", nc, BASE * 4);
    chk(rx_ready == 1'b1, "R9 receive after cal", rx_ready, 1);

    // R3: offset_zero follows cal_off while in receive
    cal_off = 1'b1;
    @(negedge clk);
    chk(offset_zero == 1'b1 && rx_ready, "R3 zero hold in receive", offset_zero, 1);
    // R9: LNA follows gain in receive
    lna_gain = 1'b1;
    @(negedge clk);
    chk(lna_en == 1'b1, "R9 LNA follows gain", lna_en, 1);
    mode = 3'b000;
    @(negedge clk);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule